// File: doc/BRIEF.md
# Randomized Trigger-Delayed Pulse Generator

This block is the timing engine of a fault-injection rig. When it has a valid configuration, it takes two random words from an outside generator. The first word picks a delay offset inside a configured range. The second picks a pulse length inside its own range. The engine then waits for a trigger. The trigger is either a rising edge on a pin (with optional inversion) or a one-cycle software strobe. If the engine is armed when the trigger comes, it waits the offset and then drives the glitch output active for the length. It then latches the offset and length it used into read-back outputs. Both times count in microsecond ticks, which a built-in prescaler makes from the system clock (one tick every `TICK_DIV` cycles, 200 by default for a 200 MHz clock).

The controller is a state machine with six states:
- `ST_STOP`: after reset, with no configuration yet.
- `ST_DRAW_OFF`: draw the offset.
- `ST_DRAW_LEN`: draw the length.
- `ST_WAIT`: idle, waiting for a trigger.
- `ST_DELAY`: counting the offset.
- `ST_PULSE`: output active.

The transitions are:
- accept: any state to `ST_DRAW_OFF`, when a valid configuration is loaded.
- draw-next: `ST_DRAW_OFF` to `ST_DRAW_LEN`.
- draw-done: `ST_DRAW_LEN` to `ST_WAIT`.
- fire: `ST_WAIT` to `ST_DELAY`, on a trigger while armed.
- discard: `ST_WAIT` to `ST_DRAW_OFF`, on a trigger while not armed.
- expire: `ST_DELAY` to `ST_PULSE`.
- cancel: `ST_DELAY` to `ST_DRAW_OFF`, in pin mode when the pin is no longer active at expiry.
- finish: `ST_PULSE` to `ST_DRAW_OFF`, with the read-back latch.

Top module: `trig_pulse_gen`

## Requirements
- R1: After reset, `glitch_out` is low, `armed`, `last_off` and `last_len` are zero, and `rand_req` stays low until the first valid configuration is accepted.
- R2: A `cfg_load` with `cfg_off_hi < cfg_off_lo` or `cfg_len_hi < cfg_len_lo` is rejected and changes nothing. An accepted load clears `armed`, `last_off` and `last_len`, and restarts the draw.
- R3: On entering the idle sequence, the engine asserts `rand_req` for exactly two consecutive cycles. The word in the first cycle gives offset = lo + word mod (hi - lo). The word in the second cycle gives the length the same way. When hi equals lo, the value is lo.
- R4: With `cfg_sw_src`=1 only a high `sw_trig` cycle triggers. With `cfg_sw_src`=0 only a rising edge of (`trig_in` XOR `cfg_trig_inv`) triggers. The other source has no effect.
- R5: `arm_set` sets and `arm_clr` clears `armed`. A trigger while `armed` is 0 gives no pulse and causes a fresh pair of draws.
- R6: An armed trigger raises the pulse at the (offset+1)-th tick after the trigger is taken. So the rise follows the trigger by between offset*TICK_DIV+1 and (offset+1)*TICK_DIV+5 cycles.
- R7: The pulse lasts exactly length*TICK_DIV cycles. A length of 0 lasts one tick.
- R8: In pin mode, if the conditioned trigger level is low when the offset expires, no pulse is driven, the read-backs are unchanged and a fresh pair is drawn.
- R9: `last_off` and `last_len` take the values used by a pulse when it ends. They change at no other time except an accepted load.
- R10: Trigger edges during the delay or the pulse are ignored. Exactly one pulse results.
- R11: `glitch_out` equals the active level XOR `cfg_out_inv`. With inversion the idle output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Load strobe for the configuration fields |
| cfg_off_lo | input | TW | Offset range lower bound, in ticks |
| cfg_off_hi | input | TW | Offset range upper bound, in ticks |
| cfg_len_lo | input | TW | Length range lower bound, in ticks |
| cfg_len_hi | input | TW | Length range upper bound, in ticks |
| cfg_trig_inv | input | 1 | Invert the trigger pin |
| cfg_out_inv | input | 1 | Invert the glitch output |
| cfg_sw_src | input | 1 | 1 selects the software strobe as the trigger source |
| arm_set | input | 1 | Set the armed bit |
| arm_clr | input | 1 | Clear the armed bit |
| trig_in | input | 1 | External trigger pin (asynchronous) |
| sw_trig | input | 1 | Software trigger strobe |
| rand_req | output | 1 | Random word consumed this cycle |
| rand_word | input | RW | Current random word |
| glitch_out | output | 1 | Glitch pulse output |
| armed | output | 1 | Armed bit |
| last_off | output | TW | Offset used by the last pulse |
| last_len | output | TW | Length used by the last pulse |

## Verification
A wrong draw order or a wrong range mapping shows at the ports as a pulse width that differs from the expected length, within one pulse. It also shows as a wrong `last_off`, a few cycles after the pulse falls. A state machine that skips the pin re-sample, or that re-arms its edge detector too early, produces a pulse that nothing expected. That pulse shows as a stray rise within one offset-plus-length window. A rejected or accepted load that handles its side effects wrongly shows at once on `armed`, on the read-backs, or on an extra pair of `rand_req` cycles.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;
    typedef enum logic [2:0] {
        ST_STOP     = 3'd0,
        ST_DRAW_OFF = 3'd1,
        ST_DRAW_LEN = 3'd2,
        ST_WAIT     = 3'd3,
        ST_DELAY    = 3'd4,
        ST_PULSE    = 3'd5
    } tpg_state_e;
endpackage

// File: rtl/tpg_tick.sv
`timescale 1ns/1ps
module tpg_tick #(
    parameter int DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CW'(1);
            tick  <= 1'b0;
        end
    end

    generate
        if (DIV > 1) begin : g_gap
            // R7: ticks are isolated single-cycle strobes
            p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tpg_trig_cond.sv
`timescale 1ns/1ps
module tpg_trig_cond #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic inv,
    output logic level,
    output logic rise
);
    localparam int SW = SYNC + 1;
    logic [SW-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SW-2:0], pin};
    end

    // inversion after the synchronizer so a polarity change alone makes no edge
    logic prev;
    assign level = sh_q[SYNC-1] ^ inv;
    assign prev  = sh_q[SYNC] ^ inv;
    assign rise  = level & ~prev;

    // R4: one pin transition yields at most one edge pulse
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && $stable(inv)) |=> !rise);
endmodule

// File: rtl/tpg_rand_scale.sv
`timescale 1ns/1ps
module tpg_rand_scale #(
    parameter int TW = 16,
    parameter int RW = 32
) (
    input  logic [RW-1:0] word,
    input  logic [TW-1:0] lo,
    input  logic [TW-1:0] hi,
    output logic [TW-1:0] val
);
    logic [TW-1:0] span;
    assign span = hi - lo;

    always_comb begin
        val = lo;
        if (span != '0) val = lo + TW'(word % RW'(span));
    end
endmodule

// File: rtl/trig_pulse_gen.sv
`timescale 1ns/1ps
module trig_pulse_gen import tpg_pkg::*; #(
    parameter int TW       = 16,
    parameter int RW       = 32,
    parameter int TICK_DIV = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [TW-1:0] cfg_off_lo,
    input  logic [TW-1:0] cfg_off_hi,
    input  logic [TW-1:0] cfg_len_lo,
    input  logic [TW-1:0] cfg_len_hi,
    input  logic          cfg_trig_inv,
    input  logic          cfg_out_inv,
    input  logic          cfg_sw_src,
    input  logic          arm_set,
    input  logic          arm_clr,
    input  logic          trig_in,
    input  logic          sw_trig,
    output logic          rand_req,
    input  logic [RW-1:0] rand_word,
    output logic          glitch_out,
    output logic          armed,
    output logic [TW-1:0] last_off,
    output logic [TW-1:0] last_len
);
    tpg_state_e    state_q, state_d;
    logic [TW-1:0] off_lo_q, off_hi_q, len_lo_q, len_hi_q;
    logic          trig_inv_q, out_inv_q, sw_src_q;
    logic          armed_q;
    logic [TW-1:0] off_q, len_q, cnt_q;
    logic [TW-1:0] last_off_q, last_len_q;
    logic          act_q;
    logic          cfg_ok, cfg_accept;
    logic          tick, trig_lvl, trig_rise, trig_fire;
    logic          pulse_end;
    logic [TW-1:0] map_lo, map_hi, map_val;

    assign cfg_ok     = (cfg_off_hi >= cfg_off_lo) && (cfg_len_hi >= cfg_len_lo);
    assign cfg_accept = cfg_load && cfg_ok;

    // ---------------- configuration and arm ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_lo_q   <= '0;
            off_hi_q   <= '0;
            len_lo_q   <= '0;
            len_hi_q   <= '0;
            trig_inv_q <= 1'b0;
            out_inv_q  <= 1'b0;
            sw_src_q   <= 1'b0;
        end else if (cfg_accept) begin
            off_lo_q   <= cfg_off_lo;
            off_hi_q   <= cfg_off_hi;
            len_lo_q   <= cfg_len_lo;
            len_hi_q   <= cfg_len_hi;
            trig_inv_q <= cfg_trig_inv;
            out_inv_q  <= cfg_out_inv;
            sw_src_q   <= cfg_sw_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          armed_q <= 1'b0;
        else if (cfg_accept) armed_q <= 1'b0;
        else if (arm_set)    armed_q <= 1'b1;
        else if (arm_clr)    armed_q <= 1'b0;
    end

    // ---------------- helpers ----------------
    tpg_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    tpg_trig_cond #(.SYNC(2)) u_trig (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (trig_in),
        .inv  (trig_inv_q),
        .level(trig_lvl),
        .rise (trig_rise)
    );

    assign map_lo = (state_q == ST_DRAW_LEN) ? len_lo_q : off_lo_q;
    assign map_hi = (state_q == ST_DRAW_LEN) ? len_hi_q : off_hi_q;

    tpg_rand_scale #(.TW(TW), .RW(RW)) u_scale (
        .word(rand_word),
        .lo  (map_lo),
        .hi  (map_hi),
        .val (map_val)
    );

    assign trig_fire = sw_src_q ? sw_trig : trig_rise;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:     state_d = ST_STOP;
            ST_DRAW_OFF: state_d = ST_DRAW_LEN;
            ST_DRAW_LEN: state_d = ST_WAIT;
            ST_WAIT: begin
                if (trig_fire) state_d = armed_q ? ST_DELAY : ST_DRAW_OFF;
            end
            ST_DELAY: begin
                if (tick && cnt_q == '0)
                    state_d = (!sw_src_q && !trig_lvl) ? ST_DRAW_OFF : ST_PULSE;
            end
            ST_PULSE: begin
                if (tick && cnt_q <= TW'(1)) state_d = ST_DRAW_OFF;
            end
            default:     state_d = ST_STOP;
        endcase
        if (cfg_accept) state_d = ST_DRAW_OFF;
    end

    assign pulse_end = (state_q == ST_PULSE) && (state_d != ST_PULSE) && !cfg_accept;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q      <= '0;
            len_q      <= '0;
            cnt_q      <= '0;
            act_q      <= 1'b0;
            last_off_q <= '0;
            last_len_q <= '0;
        end else begin
            if (state_q == ST_DRAW_OFF) off_q <= map_val;
            if (state_q == ST_DRAW_LEN) len_q <= map_val;

            if (state_q == ST_WAIT && state_d == ST_DELAY)
                cnt_q <= off_q;
            else if (state_q == ST_DELAY && state_d == ST_PULSE)
                cnt_q <= len_q;
            else if (tick && cnt_q != '0 &&
                     (state_q == ST_DELAY || state_q == ST_PULSE))
                cnt_q <= cnt_q - TW'(1);

            act_q <= (state_d == ST_PULSE);

            if (cfg_accept) begin
                last_off_q <= '0;
                last_len_q <= '0;
            end else if (pulse_end) begin
                last_off_q <= off_q;
                last_len_q <= len_q;
            end
        end
    end

    assign rand_req   = (state_q == ST_DRAW_OFF) || (state_q == ST_DRAW_LEN);
    assign glitch_out = act_q ^ out_inv_q;
    assign armed      = armed_q;
    assign last_off   = last_off_q;
    assign last_len   = last_len_q;

    // ---------------- assertions ----------------
    p_stop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> (!act_q && !rand_req));

    p_accept_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_accept |=> (!armed_q && last_off_q == '0 && last_len_q == '0
                        && state_q == ST_DRAW_OFF));

    p_reject_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !cfg_ok) |=> ($stable(off_lo_q) && $stable(off_hi_q)
                                   && $stable(len_lo_q) && $stable(len_hi_q)));

    p_draw_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAW_OFF && !cfg_accept) |=> (state_q == ST_DRAW_LEN));

    p_off_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAW_OFF && !cfg_accept) |=> (off_q >= off_lo_q && off_q <= off_hi_q));

    p_unarmed_no_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !armed_q) |=> (state_q != ST_DELAY));

    p_rise_from_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> ($past(state_q) == ST_DELAY));

    p_readback_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_end && !cfg_accept) |=> ($stable(last_off_q) && $stable(last_len_q)));
endmodule

// File: tb/test_trig_pulse_gen.sv
`timescale 1ns/1ps
module test_trig_pulse_gen;
    localparam int TD = 200;

    logic        clk, rst_n;
    logic        cfg_load;
    logic [15:0] cfg_off_lo, cfg_off_hi, cfg_len_lo, cfg_len_hi;
    logic        cfg_trig_inv, cfg_out_inv, cfg_sw_src;
    logic        arm_set, arm_clr, trig_in, sw_trig;
    logic        rand_req;
    logic [31:0] rand_word;
    logic        glitch_out, armed;
    logic [15:0] last_off, last_len;

    trig_pulse_gen i_trig_pulse_gen (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_off_lo(cfg_off_lo), .cfg_off_hi(cfg_off_hi),
        .cfg_len_lo(cfg_len_lo), .cfg_len_hi(cfg_len_hi),
        .cfg_trig_inv(cfg_trig_inv), .cfg_out_inv(cfg_out_inv), .cfg_sw_src(cfg_sw_src),
        .arm_set(arm_set), .arm_clr(arm_clr), .trig_in(trig_in), .sw_trig(sw_trig),
        .rand_req(rand_req), .rand_word(rand_word),
        .glitch_out(glitch_out), .armed(armed), .last_off(last_off), .last_len(last_len)
    );

    typedef struct { int unsigned tcyc; int off; int len; } item_t;
    item_t       sbq[$];
    int unsigned cyc = 0;
    int          nchk = 0, nfail = 0;
    int unsigned ndraw = 0, ridx = 0;
    logic [31:0] w_off = '0, w_len = '0;
    bit          cur_out_inv = 0, cur_trig_inv = 0, act_now = 0, done = 0;
    int          cur_olo = 0, cur_ohi = 0, cur_llo = 0, cur_lhi = 0;

    function automatic logic [31:0] rw(int unsigned i);
        return i * 32'h9E3779B1 + 32'h01234567;
    endfunction

    function automatic int scale(logic [31:0] w, int lo, int hi);
        if (hi == lo) return lo;
        return lo + int'(w % 32'(hi - lo));
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    initial begin
        clk = 1'b0;
        forever #2.5 clk = ~clk;
    end

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // random word source: advances after each consumed word
    initial begin
        rand_word = rw(0);
        forever begin
            @(negedge clk);
            if (rst_n && rand_req === 1'b1) begin
                if (ndraw % 2 == 0) w_off = rand_word;
                else                w_len = rand_word;
                ndraw++;
                @(posedge clk);
                #1;
                ridx++;
                rand_word = rw(ridx);
            end
        end
    end

    // monitor: measures each pulse and compares with the scoreboard head
    initial begin
        bit          prev, stray;
        int unsigned rc, d;
        item_t       it;
        prev = 0; stray = 0; rc = 0;
        forever begin
            @(negedge clk);
            act_now = rst_n && (glitch_out ^ cur_out_inv);
            if (act_now && !prev) begin
                rc = cyc;
                stray = (sbq.size() == 0);
                if (stray) check(0, "R10", "unexpected pulse", 1, 0);
            end else if (!act_now && prev && !stray) begin
                it = sbq.pop_front();
                check(cyc - rc == ((it.len == 0) ? 1 : it.len) * TD, "R7", "pulse width",
                      cyc - rc, ((it.len == 0) ? 1 : it.len) * TD);
                d = rc - it.tcyc;
                check(d >= it.off * TD + 1 && d <= it.off * TD + TD + 5, "R6",
                      "trigger to rise", d, it.off * TD + TD);
            end
            prev = act_now;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(0, "R6", "watchdog expired", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    task automatic cyc_wait(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_cfg(input int olo, input int ohi, input int llo, input int lhi,
                            input bit tinv, input bit oinv, input bit sw);
        bit ok;
        ok = (ohi >= olo) && (lhi >= llo);
        cfg_off_lo = 16'(olo); cfg_off_hi = 16'(ohi);
        cfg_len_lo = 16'(llo); cfg_len_hi = 16'(lhi);
        cfg_trig_inv = tinv; cfg_out_inv = oinv; cfg_sw_src = sw;
        if (ok) trig_in = tinv;
        cfg_load = 1'b1;
        @(posedge clk);
        #1;
        cfg_load = 1'b0;
        if (ok) begin
            cur_out_inv = oinv; cur_trig_inv = tinv;
            cur_olo = olo; cur_ohi = ohi; cur_llo = llo; cur_lhi = lhi;
        end
    endtask

    task automatic arm();
        arm_set = 1'b1;
        @(posedge clk);
        #1;
        arm_set = 1'b0;
    endtask

    task automatic after_pulse(input int eo, input int el, input int unsigned d0);
        wait (sbq.size() == 0);
        cyc_wait(10);
        check(last_off == 16'(eo), "R9", "last_off after pulse", last_off, eo);
        check(last_len == 16'(el), "R9", "last_len after pulse", last_len, el);
        check(ndraw == d0 + 2, "R3", "redraw after pulse", ndraw, d0 + 2);
    endtask

    task automatic fire_ext(input bit expect_pulse, input int hold, input bit bounce,
                            input string rq);
        int          eo, el;
        int unsigned d0;
        logic [15:0] lo0, ll0;
        eo = scale(w_off, cur_olo, cur_ohi);
        el = scale(w_len, cur_llo, cur_lhi);
        d0 = ndraw; lo0 = last_off; ll0 = last_len;
        if (expect_pulse) sbq.push_back('{cyc, eo, el});
        trig_in = !cur_trig_inv;
        if (expect_pulse) begin
            if (bounce) begin
                wait (act_now);
                for (int k = 0; k < 3; k++) begin
                    cyc_wait(20);
                    trig_in = cur_trig_inv;
                    cyc_wait(5);
                    trig_in = !cur_trig_inv;
                end
            end
            wait (sbq.size() == 0);
            trig_in = cur_trig_inv;
            after_pulse(eo, el, d0);
            if (bounce) cyc_wait((cur_ohi + cur_lhi + 3) * TD);
        end else begin
            cyc_wait(hold);
            trig_in = cur_trig_inv;
            cyc_wait((cur_ohi + cur_lhi + 3) * TD);
            check(last_off == lo0 && last_len == ll0, rq, "read-back kept without pulse",
                  {last_off, last_len}, {lo0, ll0});
            check(ndraw == d0 + 2, rq, "fresh draws without pulse", ndraw, d0 + 2);
        end
    endtask

    task automatic fire_sw();
        int          eo, el;
        int unsigned d0;
        eo = scale(w_off, cur_olo, cur_ohi);
        el = scale(w_len, cur_llo, cur_lhi);
        d0 = ndraw;
        sbq.push_back('{cyc, eo, el});
        sw_trig = 1'b1;
        @(posedge clk);
        #1;
        sw_trig = 1'b0;
        after_pulse(eo, el, d0);
    endtask

    initial begin
        int unsigned d0;
        rst_n = 1'b0; cfg_load = 1'b0;
        cfg_off_lo = '0; cfg_off_hi = '0; cfg_len_lo = '0; cfg_len_hi = '0;
        cfg_trig_inv = 1'b0; cfg_out_inv = 1'b0; cfg_sw_src = 1'b0;
        arm_set = 1'b0; arm_clr = 1'b0; trig_in = 1'b0; sw_trig = 1'b0;
        cyc_wait(4);
        rst_n = 1'b1;
        cyc_wait(5);

        // R1: reset state
        check(glitch_out == 1'b0, "R1", "glitch_out after reset", glitch_out, 0);
        check(armed == 1'b0, "R1", "armed after reset", armed, 0);
        check(last_off == 0 && last_len == 0, "R1", "read-backs after reset",
              {last_off, last_len}, 0);
        check(ndraw == 0, "R1", "no draws before config", ndraw, 0);

        // R2: rejected configuration does not start the engine
        load_cfg(5, 2, 1, 3, 0, 0, 0);
        cyc_wait(5);
        check(ndraw == 0, "R2", "rejected config draws nothing", ndraw, 0);

        // config A: pin mode, ranged values
        load_cfg(0, 4, 1, 3, 0, 0, 0);
        cyc_wait(4);
        check(ndraw == 2, "R3", "two draws after accept", ndraw, 2);
        check(armed == 1'b0, "R2", "accept leaves armed clear", armed, 0);
        arm();
        check(armed == 1'b1, "R5", "arm_set sets armed", armed, 1);
        for (int i = 0; i < 3; i++) fire_ext(1, 0, 0, "R6");

        // R2: rejected config keeps armed and the old ranges
        load_cfg(7, 1, 1, 1, 0, 0, 0);
        cyc_wait(4);
        check(armed == 1'b1, "R2", "rejected config keeps armed", armed, 1);
        fire_ext(1, 0, 0, "R2");

        // R5: unarmed trigger ignored, fresh draws
        arm_clr = 1'b1;
        cyc_wait(1);
        arm_clr = 1'b0;
        check(armed == 1'b0, "R5", "arm_clr clears armed", armed, 0);
        fire_ext(0, 20, 0, "R5");
        arm();

        // config B: fixed values, cancel and bounce
        load_cfg(3, 3, 2, 2, 0, 0, 0);
        cyc_wait(4);
        check(last_off == 0 && last_len == 0, "R2", "accept clears read-backs",
              {last_off, last_len}, 0);
        check(armed == 1'b0, "R2", "accept clears armed", armed, 0);
        arm();
        fire_ext(0, 5, 0, "R8");
        fire_ext(1, 0, 1, "R10");
        check(last_off == 3 && last_len == 2, "R3", "equal bounds give lo",
              {last_off, last_len}, {16'd3, 16'd2});

        // config C: software source, inverted output
        load_cfg(1, 6, 1, 4, 0, 1, 1);
        cyc_wait(4);
        check(glitch_out == 1'b1, "R11", "inverted idle output", glitch_out, 1);
        arm();
        d0 = ndraw;
        trig_in = 1'b1;
        cyc_wait(10);
        trig_in = 1'b0;
        cyc_wait(12 * TD);
        check(ndraw == d0, "R4", "pin ignored in software mode", ndraw, d0);
        fire_sw();
        fire_sw();

        // config D: pin mode, inverted pin
        load_cfg(0, 2, 2, 5, 1, 0, 0);
        cyc_wait(4);
        check(glitch_out == 1'b0, "R11", "normal idle output", glitch_out, 0);
        arm();
        d0 = ndraw;
        sw_trig = 1'b1;
        cyc_wait(1);
        sw_trig = 1'b0;
        cyc_wait(10 * TD);
        check(ndraw == d0 && last_off == 0, "R4", "strobe ignored in pin mode", ndraw, d0);
        fire_ext(1, 0, 0, "R4");
        fire_ext(1, 0, 0, "R4");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule